// File: doc/BRIEF.md
# Cascadable Timer Counter Pair

This block holds two 16-bit up/down counting channels, a lower one and an upper one. Each channel counts on its own, either prescaled clock ticks or the position of a two-phase encoder. A channel in encoder mode decodes all four edges of each cycle and takes the direction from the phase relationship of its two inputs. The prescaler enables come from outside the block as single-cycle strobes at 1/4, 1/16 and 1/64 of the system clock.

When the upper channel's clock-select field holds the cascade code and the upper channel is not itself in encoder mode, the upper channel stops counting ticks. It then counts the lower channel's wrap events instead. The upper channel steps up when the lower channel wraps past its top value and steps down when it wraps below zero. The pair then reads as one 32-bit count: the upper value is bits 31:16 and the lower value is bits 15:0. With the lower channel on an encoder, that count follows the encoder position in both directions. Each channel keeps sticky wrap-up and wrap-down flags, which a common clear pulse resets.

Top module: `cascade_timer_pair`

## Requirements
- R1: With the upper channel in cascade (clock-select 3'b111, upper encoder mode off), a lower-channel step from 0xFFFF to 0x0000 increments the upper channel by one at the same clock edge.
- R2: In cascade, a lower-channel step from 0x0000 to 0xFFFF (encoder mode only) decrements the upper channel at the same edge. Across any walk of the lower encoder, {upper, lower} equals the 32-bit net step count.
- R3: With its encoder mode off, the lower channel only counts up, and its wrap-down flag never sets.
- R4: With the upper encoder mode on, the upper channel's clock-select value, including 3'b111, has no effect. The upper channel counts only its own phase inputs, and lower-channel wraps leave it unchanged.
- R5: A channel's value changes only on a cycle where its start bit is 1. A lower-channel wrap that occurs while the upper start bit is 0 is lost, not stored for later.
- R6: Encoder mode counts 4x. With phases {A,B}, the sequence 00→10→11→01→00 counts up and the reverse sequence counts down. A cycle in which both synchronised phases change does not count. A phase change takes effect on the count three clock edges after it is sampled, because of two synchroniser flops and one edge-detect flop.
- R7: Clock-select codes 3'b000, 3'b001, 3'b010 and 3'b011 count on every cycle, on tick_div4, on tick_div16 and on tick_div64 respectively. Codes 3'b100 to 3'b111 on the lower channel (and 3'b100 to 3'b110 on the upper) never count.
- R8: A channel's wrap-up and wrap-down flags set on the matching wrap and stay set until flag_clr is high at a clock edge. A wrap in that same cycle keeps its flag set.
- R9: After reset both counts are 0 and all four flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_div4 | input | 1 | Prescaler strobe, 1/4 rate |
| tick_div16 | input | 1 | Prescaler strobe, 1/16 rate |
| tick_div64 | input | 1 | Prescaler strobe, 1/64 rate |
| lo_pha | input | 1 | Lower channel phase A |
| lo_phb | input | 1 | Lower channel phase B |
| hi_pha | input | 1 | Upper channel phase A |
| hi_phb | input | 1 | Upper channel phase B |
| lo_run | input | 1 | Lower channel start bit |
| hi_run | input | 1 | Upper channel start bit |
| lo_csel | input | 3 | Lower channel clock select |
| hi_csel | input | 3 | Upper channel clock select (3'b111 = cascade) |
| lo_quad | input | 1 | Lower channel encoder mode |
| hi_quad | input | 1 | Upper channel encoder mode |
| flag_clr | input | 1 | Clear pulse for all four flags |
| lo_count | output | 16 | Lower channel value, bits 15:0 of the joined count |
| hi_count | output | 16 | Upper channel value, bits 31:16 of the joined count |
| lo_ovf | output | 1 | Lower channel sticky wrap-up flag |
| lo_unf | output | 1 | Lower channel sticky wrap-down flag |
| hi_ovf | output | 1 | Upper channel sticky wrap-up flag |
| hi_unf | output | 1 | Upper channel sticky wrap-down flag |

## Verification
The hardest case to reach is a borrow into the upper channel. It needs the lower channel in encoder mode to pass below zero, and the stimulus must pass through three flop stages before each step lands. The stimulus drives a random walk of encoder steps from position zero, with a fixed seed. The walk crosses zero in both directions many times, and some of its steps flip both phases at once. A bench model tracks the 32-bit position and the flags after every step. Directed cases cover a full 65,536-tick carry in normal mode, a wrap lost while the upper channel is stopped, and the cascade code being ignored when the upper channel is in encoder mode.

// File: rtl/cascade_timer_pair.sv
module cascade_timer_pair #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_div4,
  input  logic         tick_div16,
  input  logic         tick_div64,
  input  logic         lo_pha,
  input  logic         lo_phb,
  input  logic         hi_pha,
  input  logic         hi_phb,
  input  logic         lo_run,
  input  logic         hi_run,
  input  logic [2:0]   lo_csel,
  input  logic [2:0]   hi_csel,
  input  logic         lo_quad,
  input  logic         hi_quad,
  input  logic         flag_clr,
  output logic [W-1:0] lo_count,
  output logic [W-1:0] hi_count,
  output logic         lo_ovf,
  output logic         lo_unf,
  output logic         hi_ovf,
  output logic         hi_unf
);
  localparam logic [2:0] CASCADE = 3'b111;

  // [0] first sync flop, [1] synchronised, [2] previous for edge detect
  logic [2:0] lo_sa, lo_sb, hi_sa, hi_sb;

  function automatic logic [1:0] quad_step(input logic [2:0] a, input logic [2:0] b);
    logic ea, eb, lead;
    ea   = a[1] ^ a[2];
    eb   = b[1] ^ b[2];
    lead = a[1] ^ b[1];
    if (ea && !eb)      quad_step = lead ? 2'b10 : 2'b01;
    else if (eb && !ea) quad_step = lead ? 2'b01 : 2'b10;
    else                quad_step = 2'b00;
  endfunction

  function automatic logic sel_tick(input logic [2:0] cs, input logic t4, input logic t16,
                                    input logic t64);
    case (cs)
      3'b000:  sel_tick = 1'b1;
      3'b001:  sel_tick = t4;
      3'b010:  sel_tick = t16;
      3'b011:  sel_tick = t64;
      default: sel_tick = 1'b0;
    endcase
  endfunction

  logic [1:0] lo_q, hi_q;
  logic lo_up, lo_dn, hi_up, hi_dn, lo_wrap_up, lo_wrap_dn, hi_wrap_up, hi_wrap_dn, hi_casc;

  assign lo_q = quad_step(lo_sa, lo_sb);
  assign hi_q = quad_step(hi_sa, hi_sb);

  assign lo_up = lo_run & (lo_quad ? lo_q[1] : sel_tick(lo_csel, tick_div4, tick_div16, tick_div64));
  assign lo_dn = lo_run & lo_quad & lo_q[0];
  assign lo_wrap_up = lo_up & (&lo_count);
  assign lo_wrap_dn = lo_dn & (lo_count == '0);

  assign hi_casc = !hi_quad && hi_csel == CASCADE;
  assign hi_up = hi_run & (hi_quad ? hi_q[1] :
                           hi_casc ? lo_wrap_up : sel_tick(hi_csel, tick_div4, tick_div16, tick_div64));
  assign hi_dn = hi_run & (hi_quad ? hi_q[0] : (hi_casc & lo_wrap_dn));
  assign hi_wrap_up = hi_up & (&hi_count);
  assign hi_wrap_dn = hi_dn & (hi_count == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_sa <= '0; lo_sb <= '0; hi_sa <= '0; hi_sb <= '0;
      lo_count <= '0; hi_count <= '0;
      lo_ovf <= 1'b0; lo_unf <= 1'b0; hi_ovf <= 1'b0; hi_unf <= 1'b0;
    end else begin
      lo_sa <= {lo_sa[1:0], lo_pha};
      lo_sb <= {lo_sb[1:0], lo_phb};
      hi_sa <= {hi_sa[1:0], hi_pha};
      hi_sb <= {hi_sb[1:0], hi_phb};
      if (lo_up)      lo_count <= lo_count + 1'b1;
      else if (lo_dn) lo_count <= lo_count - 1'b1;
      if (hi_up)      hi_count <= hi_count + 1'b1;
      else if (hi_dn) hi_count <= hi_count - 1'b1;
      lo_ovf <= lo_wrap_up | (lo_ovf & ~flag_clr);
      lo_unf <= lo_wrap_dn | (lo_unf & ~flag_clr);
      hi_ovf <= hi_wrap_up | (hi_ovf & ~flag_clr);
      hi_unf <= hi_wrap_dn | (hi_unf & ~flag_clr);
    end
  end
endmodule

// File: rtl/cascade_timer_pair_chk.sv
module cascade_timer_pair_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         lo_run,
  input logic         hi_run,
  input logic [2:0]   lo_csel,
  input logic [2:0]   hi_csel,
  input logic         lo_quad,
  input logic         hi_quad,
  input logic         flag_clr,
  input logic [W-1:0] lo_count,
  input logic [W-1:0] hi_count,
  input logic         lo_ovf,
  input logic         lo_unf
);
  AST_LO_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !lo_run |=> $stable(lo_count)); // R5
  AST_HI_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !hi_run |=> $stable(hi_count)); // R5
  AST_CASCADE_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_run && hi_run && !lo_quad && !hi_quad && lo_csel == 3'b000 && hi_csel == 3'b111
     && lo_count == {W{1'b1}}) |=> (lo_count == '0 && hi_count == $past(hi_count) + 1'b1)); // R1
  AST_NO_UNDERFLOW_NORMAL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lo_unf) |-> $past(lo_quad)); // R3
  AST_UNUSED_CSEL: assert property (@(posedge clk) disable iff (!rst_n)
    (!lo_quad && lo_csel[2]) |=> $stable(lo_count)); // R7
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_ovf && !flag_clr) |=> lo_ovf); // R8
endmodule

bind cascade_timer_pair cascade_timer_pair_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .lo_run(lo_run), .hi_run(hi_run), .lo_csel(lo_csel),
  .hi_csel(hi_csel), .lo_quad(lo_quad), .hi_quad(hi_quad), .flag_clr(flag_clr),
  .lo_count(lo_count), .hi_count(hi_count), .lo_ovf(lo_ovf), .lo_unf(lo_unf)
);

// File: tb/sim_cascade_timer_pair.sv
module sim_cascade_timer_pair;
  logic clk = 1'b0, rst_n = 1'b0;
  logic tick_div4 = 0, tick_div16 = 0, tick_div64 = 0;
  logic lo_pha = 0, lo_phb = 0, hi_pha = 0, hi_phb = 0;
  logic lo_run = 0, hi_run = 0, lo_quad = 0, hi_quad = 0, flag_clr = 0;
  logic [2:0] lo_csel = 0, hi_csel = 0;
  logic [15:0] lo_count, hi_count;
  logic lo_ovf, lo_unf, hi_ovf, hi_unf;
  int tests = 0, fails = 0;
  int lo_idx = 0, hi_idx = 0;

  always #10 clk = ~clk;

  cascade_timer_pair u0 (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [1:0] phases(input int idx);
    phases = {idx == 1 || idx == 2, idx >= 2};
  endfunction

  function automatic logic [31:0] joined_step(input logic [31:0] pos, input int d);
    joined_step = pos + 32'(d);
  endfunction

  task automatic reset_all();
    @(negedge clk);
    rst_n = 0; lo_run = 0; hi_run = 0; lo_quad = 0; hi_quad = 0; flag_clr = 0;
    lo_csel = 0; hi_csel = 0; lo_pha = 0; lo_phb = 0; hi_pha = 0; hi_phb = 0;
    lo_idx = 0; hi_idx = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic lo_step(input int d);
    lo_idx = (lo_idx + d) & 3;
    {lo_pha, lo_phb} = phases(lo_idx);
    repeat (4) @(negedge clk);
  endtask

  task automatic hi_step(input int d);
    hi_idx = (hi_idx + d) & 3;
    {hi_pha, hi_phb} = phases(hi_idx);
    repeat (4) @(negedge clk);
  endtask

  task automatic run_lo(input int n);
    lo_run = 1;
    repeat (n) @(negedge clk);
    lo_run = 0;
  endtask

  task automatic pulse(input int which);
    if (which == 4) tick_div4 = 1; else if (which == 16) tick_div16 = 1; else tick_div64 = 1;
    @(negedge clk);
    tick_div4 = 0; tick_div16 = 0; tick_div64 = 0;
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin : main
    logic [31:0] pos;
    logic m_lo_ovf, m_lo_unf, m_hi_ovf, m_hi_unf;
    void'($urandom(32'h5eed_0c1a));
    reset_all();
    chk("R9 counts", {hi_count, lo_count}, 32'h0);
    chk("R9 flags", {28'h0, lo_ovf, lo_unf, hi_ovf, hi_unf}, 32'h0);

    // R7 clock selection
    lo_csel = 3'd0; run_lo(10);
    chk("R7 div1", {16'h0, lo_count}, 32'd10);
    lo_csel = 3'd1; lo_run = 1;
    for (int i = 0; i < 5; i++) pulse(4);
    pulse(16);
    lo_run = 0;
    chk("R7 div4", {16'h0, lo_count}, 32'd15);
    lo_csel = 3'd2; lo_run = 1;
    for (int i = 0; i < 3; i++) pulse(16);
    pulse(4); pulse(64);
    lo_run = 0;
    chk("R7 div16", {16'h0, lo_count}, 32'd18);
    lo_csel = 3'd3; lo_run = 1;
    pulse(64); pulse(4);
    lo_run = 0;
    chk("R7 div64", {16'h0, lo_count}, 32'd19);
    lo_csel = 3'd5; lo_run = 1; tick_div4 = 1; tick_div16 = 1; tick_div64 = 1;
    repeat (20) @(negedge clk);
    lo_run = 0; tick_div4 = 0; tick_div16 = 0; tick_div64 = 0;
    chk("R7 unused code", {16'h0, lo_count}, 32'd19);

    // R5 start bit gating
    lo_csel = 3'd0; lo_run = 0;
    repeat (20) @(negedge clk);
    chk("R5 lower stopped", {16'h0, lo_count}, 32'd19);

    // R1, R3: full carry in normal mode, then flag clear (R8)
    reset_all();
    hi_csel = 3'b111; hi_run = 1; lo_csel = 3'd0;
    run_lo(65536 + 5);
    chk("R1 joined after carry", {hi_count, lo_count}, 32'h0001_0005);
    chk("R3 flags after carry", {28'h0, lo_ovf, lo_unf, hi_ovf, hi_unf}, 32'b1000);
    flag_clr = 1; @(negedge clk); flag_clr = 0;
    chk("R8 clear", {28'h0, lo_ovf, lo_unf, hi_ovf, hi_unf}, 32'h0);
    repeat (3) @(negedge clk);
    chk("R8 stays clear", {31'h0, lo_ovf}, 32'h0);

    // R5 lost wrap while upper stopped
    reset_all();
    lo_quad = 1; lo_run = 1; hi_csel = 3'b111; hi_run = 0;
    lo_step(-1);
    chk("R5 lower wrapped down", {hi_count, lo_count}, 32'h0000_FFFF);
    chk("R2 lower unf flag", {31'h0, lo_unf}, 32'h1);
    hi_run = 1;
    lo_step(1);
    chk("R5 borrow lost", {hi_count, lo_count}, 32'h0001_0000);
    chk("R8 ovf and unf sticky", {30'h0, lo_ovf, lo_unf}, 32'b11);

    // R4 upper encoder ignores cascade code
    reset_all();
    lo_quad = 1; lo_run = 1; hi_quad = 1; hi_csel = 3'b111; hi_run = 1;
    lo_step(-1);
    chk("R4 no borrow", {hi_count, lo_count}, 32'h0000_FFFF);
    hi_step(1); hi_step(1);
    chk("R4 own phases up", {hi_count, lo_count}, 32'h0002_FFFF);
    hi_step(-1); hi_step(-1); hi_step(-1);
    chk("R4 own phases down", {hi_count, lo_count}, 32'hFFFF_FFFF);
    chk("R4 upper unf", {31'h0, hi_unf}, 32'h1);

    // R6 simultaneous change
    reset_all();
    lo_quad = 1; lo_run = 1;
    lo_step(2);
    chk("R6 both phases flip", {16'h0, lo_count}, 32'h0);
    lo_step(1); lo_step(1); lo_step(1);
    chk("R6 4x up", {16'h0, lo_count}, 32'd3);

    // R2 random walk of the joined count
    reset_all();
    lo_quad = 1; lo_run = 1; hi_csel = 3'b111; hi_run = 1;
    pos = 0; m_lo_ovf = 0; m_lo_unf = 0; m_hi_ovf = 0; m_hi_unf = 0;
    for (int i = 0; i < 400; i++) begin
      int r;
      r = int'($urandom_range(0, 9));
      if (r == 0) begin
        lo_step(2);
      end else begin
        int d;
        d = (r <= 4) ? 1 : -1;
        if (d == 1 && pos[15:0] == 16'hFFFF) begin
          m_lo_ovf = 1; if (pos[31:16] == 16'hFFFF) m_hi_ovf = 1;
        end
        if (d == -1 && pos[15:0] == 16'h0000) begin
          m_lo_unf = 1; if (pos[31:16] == 16'h0000) m_hi_unf = 1;
        end
        pos = joined_step(pos, d);
        lo_step(d);
      end
      if (i % 20 == 19) chk("R2 walk position", {hi_count, lo_count}, pos);
    end
    chk("R2 walk final", {hi_count, lo_count}, pos);
    chk("R8 walk flags", {28'h0, lo_ovf, lo_unf, hi_ovf, hi_unf},
        {28'h0, m_lo_ovf, m_lo_unf, m_hi_ovf, m_hi_unf});

    // R2 directed borrow across zero
    reset_all();
    lo_quad = 1; lo_run = 1; hi_csel = 3'b111; hi_run = 1;
    lo_step(1); lo_step(-1); lo_step(-1);
    chk("R2 borrow", {hi_count, lo_count}, 32'hFFFF_FFFF);
    chk("R2 upper unf", {30'h0, hi_unf, lo_unf}, 32'b11);
    lo_step(1);
    chk("R1 carry back", {hi_count, lo_count}, 32'h0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule